// File: doc/BRIEF.md
# Interrupt Flag and Reset Controller

This block holds the interrupt state of a timekeeping peripheral. Three event sources (a periodic tick, an alarm match and the end of a time update) deliver one-cycle pulses from logic outside the block. Each pulse latches a sticky flag. A per-source enable decides whether that flag also pulls the interrupt line low. The interrupt output is modelled as an open-drain drive enable: when it is 1, the pin is pulled low; when it is 0, the pin floats and an external pull-up holds it high.

Software sees two registers. The control register holds the three enables, a square-wave output enable and the level of a chip-enable-out control. The status register shows the three flags and a combined request bit. Reading the status register returns the flags and clears them in the same access. A separate external reset pin returns the interrupt and output controls to a safe state while the supply is good. It does not touch any timekeeping or storage state. While the supply is below threshold, the block refuses bus accesses and ignores the reset pin.

Top module: `rtc_irq_ctl`

## Requirements
- R1: A pulse on `evt_periodic`, `evt_alarm` or `evt_update` sets status bit 0, 1 or 2 respectively on the next clock edge, whatever the enable bits hold.
- R2: `irq_drive_low` is 1 exactly when some status flag is set together with its enable. The enables are control bits 0 (periodic), 1 (alarm) and 2 (update). Status bit 7 reads back this same combined request.
- R3: A flag stays set until a status read or a reset clears it. A read strobe at address 1 places the status value on `rd_data` after the next clock edge and clears all flags on that edge, which releases `irq_drive_low`.
- R4: An event that arrives in the same cycle as a clearing status read leaves its flag set after the read. The read data shows the flags as they were before that edge.
- R5: A write at address 0 stores data bits 2:0 as the enables, bit 3 as `sqw_en` and bit 4 as `chip_en_out`. A read at address 0 returns these five bits, with bits 7:5 reading as 0.
- R6: When `ext_reset_n` is low and `supply_ok` is 1, the next edge does the following: it clears the enables, all flags and `sqw_en`, sets `chip_en_out` to 1 and releases `irq_drive_low`. Events that arrive during this reset are discarded.
- R7: When `supply_ok` is 0, a low `ext_reset_n` has no effect. The enables, the flags, `sqw_en` and `chip_en_out` keep their values.
- R8: While `ext_reset_n` is low or `supply_ok` is 0, bus strobes are ignored. Writes leave the control register unchanged, reads leave `rd_data` unchanged, and status reads clear no flags.
- R9: A low `rst_n` at a clock edge clears the enables, the flags, `sqw_en` and `rd_data`, and sets `chip_en_out` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ext_reset_n | input | 1 | External reset pin, active low |
| supply_ok | input | 1 | 1 while the supply is above the access threshold |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_drive_low | output | 1 | Open-drain enable: 1 pulls the interrupt line low |
| sqw_en | output | 1 | Square-wave output enable |
| chip_en_out | output | 1 | Chip-enable-out level |

## Verification
The two functions that can coincide are the setting of a flag by an event and the clearing of all flags by a status read. The bench provokes this by raising an event pulse in the same cycle as the read strobe. It then judges two things: that the returned byte shows only the older flags, and that a second read finds the new event still latched, with its request bit. A second collision, an event arriving during the external reset, is judged by reading the status register after the reset is released and expecting zero.

// File: rtl/irq_ctl_pkg.sv
// Package: shared default sizes and register addresses for the interrupt
// flag and reset controller. Assumes a byte-wide register bus.
package irq_ctl_pkg;
    localparam int DATA_W    = 8;  // register data width
    localparam int N_EVT     = 3;  // periodic, alarm, update-ended
    localparam int ADDR_W    = 1;  // two registers
    localparam int CTRL_ADDR = 0;  // control register address
    localparam int STAT_ADDR = 1;  // status register address
endpackage

// File: rtl/irq_bus_gate.sv
// Module: irq_bus_gate
// Qualifies bus strobes with the supply flag and the external reset pin, and
// derives the pin-reset condition. Assumes strobes are single-cycle qualified
// by the caller; purely combinational.
module irq_bus_gate #(
    parameter int AW        = irq_ctl_pkg::ADDR_W,
    parameter int CTRL_ADDR = irq_ctl_pkg::CTRL_ADDR,
    parameter int STAT_ADDR = irq_ctl_pkg::STAT_ADDR
) (
    input  logic          ext_reset_n,
    input  logic          supply_ok,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    output logic          pin_reset,
    output logic          access_ok,
    output logic          ctrl_we,
    output logic          stat_clr,
    output logic          rd_en
);
    localparam logic [AW-1:0] CTRL_SEL = AW'(CTRL_ADDR);
    localparam logic [AW-1:0] STAT_SEL = AW'(STAT_ADDR);

    // Decode gating conditions and qualified strobes.
    always_comb begin
        pin_reset = supply_ok & ~ext_reset_n;
        access_ok = supply_ok & ext_reset_n;
        ctrl_we   = access_ok & reg_wr & (reg_addr == CTRL_SEL);
        stat_clr  = access_ok & reg_rd & (reg_addr == STAT_SEL);
        rd_en     = access_ok & reg_rd;
    end
endmodule

// File: rtl/irq_ctrl_reg.sv
// Module: irq_ctrl_reg
// Control register: per-event enables, square-wave enable, chip-enable-out
// level. Cleared by system reset or the qualified pin reset; chip-enable-out
// returns high. Assumes ctrl_we is already gated by bus access rules.
module irq_ctrl_reg #(
    parameter int DW = irq_ctl_pkg::DATA_W,
    parameter int NE = irq_ctl_pkg::N_EVT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_reset,
    input  logic          access_ok,
    input  logic          ctrl_we,
    input  logic [DW-1:0] wr_data,
    output logic [NE-1:0] evt_en,
    output logic          sqw_en,
    output logic          ce_level
);
    localparam int SQW_POS = NE;
    localparam int CE_POS  = NE + 1;

    logic unused_wr_hi;
    assign unused_wr_hi = ^wr_data[DW-1:CE_POS+1];

    // Hold control bits; reset has priority over a write.
    always_ff @(posedge clk) begin
        if (!rst_n || pin_reset) begin
            evt_en   <= '0;
            sqw_en   <= 1'b0;
            ce_level <= 1'b1;
        end else if (ctrl_we) begin
            evt_en   <= wr_data[NE-1:0];
            sqw_en   <= wr_data[SQW_POS];
            ce_level <= wr_data[CE_POS];
        end
    end

    AST_CTRL_PIN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        pin_reset |=> (evt_en == '0 && !sqw_en && ce_level)); // R6
    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (evt_en == $past(wr_data[NE-1:0]) && sqw_en == $past(wr_data[SQW_POS]))); // R5
    AST_CTRL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_ok && !pin_reset) |=> $stable({evt_en, sqw_en, ce_level})); // R8
endmodule

// File: rtl/irq_flag_bank.sv
// Module: irq_flag_bank
// Sticky event flags, one per source, and the combined request. An event wins
// over a same-cycle clearing read; pin reset wins over everything. Assumes
// event inputs are single-cycle pulses from the timekeeping core.
module irq_flag_bank #(
    parameter int NE = irq_ctl_pkg::N_EVT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_reset,
    input  logic          stat_clr,
    input  logic [NE-1:0] evt,
    input  logic [NE-1:0] evt_en,
    output logic [NE-1:0] flags,
    output logic          request
);
    // One flag cell per event source.
    for (genvar i = 0; i < NE; i++) begin : g_flag
        // Set on event, clear on status read, event takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n || pin_reset)
                flags[i] <= 1'b0;
            else if (evt[i])
                flags[i] <= 1'b1;
            else if (stat_clr)
                flags[i] <= 1'b0;
        end
    end

    // Combined request: any flag with its enable set.
    always_comb request = |(flags & evt_en);

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_reset |=> ((flags & $past(evt)) == $past(evt))); // R1
    AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && evt != '0 && !pin_reset) |=> (flags == $past(evt))); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_clr && !pin_reset) |=> ((flags & $past(flags)) == $past(flags))); // R3
    AST_FLAG_PIN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        pin_reset |=> (flags == '0)); // R6
endmodule

// File: rtl/irq_read_port.sv
// Module: irq_read_port
// Registered read mux for the control and status registers. Status places
// the combined request in the top bit. Assumes rd_en is already gated.
module irq_read_port #(
    parameter int DW        = irq_ctl_pkg::DATA_W,
    parameter int NE        = irq_ctl_pkg::N_EVT,
    parameter int AW        = irq_ctl_pkg::ADDR_W,
    parameter int CTRL_ADDR = irq_ctl_pkg::CTRL_ADDR,
    parameter int STAT_ADDR = irq_ctl_pkg::STAT_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          access_ok,
    input  logic          rd_en,
    input  logic [AW-1:0] reg_addr,
    input  logic [NE-1:0] evt_en,
    input  logic          sqw_en,
    input  logic          ce_level,
    input  logic [NE-1:0] flags,
    input  logic          request,
    output logic [DW-1:0] rd_data
);
    localparam int REQ_POS = DW - 1;
    localparam logic [AW-1:0] CTRL_SEL = AW'(CTRL_ADDR);
    localparam logic [AW-1:0] STAT_SEL = AW'(STAT_ADDR);

    logic [DW-1:0] rd_next;

    // Select the addressed register image.
    always_comb begin
        rd_next = '0;
        if (reg_addr == CTRL_SEL) begin
            rd_next[NE-1:0] = evt_en;
            rd_next[NE]     = sqw_en;
            rd_next[NE+1]   = ce_level;
        end else if (reg_addr == STAT_SEL) begin
            rd_next[NE-1:0] = flags;
            rd_next[REQ_POS] = request;
        end
    end

    // Capture read data on a qualified read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end

    AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !access_ok |=> $stable(rd_data)); // R8
endmodule

// File: rtl/rtc_irq_ctl.sv
// Module: rtc_irq_ctl
// Top of the interrupt flag and reset controller. Wires the bus gate, the
// control register, the flag bank and the read port. Assumes the interrupt
// pin is open-drain outside: irq_drive_low=1 pulls it low.
module rtc_irq_ctl #(
    parameter int DW = irq_ctl_pkg::DATA_W,
    parameter int NE = irq_ctl_pkg::N_EVT,
    parameter int AW = irq_ctl_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_reset_n,
    input  logic          supply_ok,
    input  logic          evt_periodic,
    input  logic          evt_alarm,
    input  logic          evt_update,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          irq_drive_low,
    output logic          sqw_en,
    output logic          chip_en_out
);
    logic          pin_reset, access_ok, ctrl_we, stat_clr, rd_en;
    logic [NE-1:0] evt_vec, evt_en, flags;
    logic          request;

    // Gather event pulses into a vector (bit 0 periodic, 1 alarm, 2 update).
    always_comb begin
        evt_vec    = '0;
        evt_vec[0] = evt_periodic;
        evt_vec[1] = evt_alarm;
        evt_vec[2] = evt_update;
    end

    irq_bus_gate #(.AW(AW)) i_gate (
        .ext_reset_n (ext_reset_n),
        .supply_ok   (supply_ok),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .pin_reset   (pin_reset),
        .access_ok   (access_ok),
        .ctrl_we     (ctrl_we),
        .stat_clr    (stat_clr),
        .rd_en       (rd_en)
    );

    irq_ctrl_reg #(.DW(DW), .NE(NE)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_reset (pin_reset),
        .access_ok (access_ok),
        .ctrl_we   (ctrl_we),
        .wr_data   (wr_data),
        .evt_en    (evt_en),
        .sqw_en    (sqw_en),
        .ce_level  (chip_en_out)
    );

    irq_flag_bank #(.NE(NE)) i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_reset (pin_reset),
        .stat_clr  (stat_clr),
        .evt       (evt_vec),
        .evt_en    (evt_en),
        .flags     (flags),
        .request   (request)
    );

    irq_read_port #(.DW(DW), .NE(NE), .AW(AW)) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .access_ok (access_ok),
        .rd_en     (rd_en),
        .reg_addr  (reg_addr),
        .evt_en    (evt_en),
        .sqw_en    (sqw_en),
        .ce_level  (chip_en_out),
        .flags     (flags),
        .request   (request),
        .rd_data   (rd_data)
    );

    // Drive the open-drain enable from the combined request.
    always_comb irq_drive_low = request;

    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && evt_vec == '0) |=> !irq_drive_low); // R3
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_reset && !ctrl_we && (evt_vec & evt_en) != '0) |=> irq_drive_low); // R2
    AST_BROWNOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> $stable({sqw_en, chip_en_out, irq_drive_low})); // R7
endmodule

// File: tb/test_rtc_irq_ctl.sv
module test_rtc_irq_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, ext_reset_n = 1'b1, supply_ok = 1'b1;
    logic       evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [0:0] reg_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_drive_low, sqw_en, chip_en_out;
    int total = 0, bad = 0;
    logic [7:0] got;

    always #2.5 clk = ~clk;

    rtc_irq_ctl i_rtc_irq_ctl (
        .clk(clk), .rst_n(rst_n), .ext_reset_n(ext_reset_n), .supply_ok(supply_ok),
        .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_drive_low(irq_drive_low), .sqw_en(sqw_en),
        .chip_en_out(chip_en_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_evt(input logic [2:0] e);
        evt_periodic = e[0]; evt_alarm = e[1]; evt_update = e[2];
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b0; wr_data = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = rd_data;
    endtask

    task automatic pulse(input logic [2:0] e);
        @(negedge clk); set_evt(e);
        @(negedge clk); set_evt(3'b000);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] wd, expv;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 rd_data", rd_data, 8'h00);
        chk("R9 irq", {7'b0, irq_drive_low}, 8'h00);
        chk("R9 sqw/ce", {6'b0, sqw_en, chip_en_out}, 8'h01);
        rst_n = 1'b1;
        rd_reg(1'b0, got); chk("R9 ctrl after reset", got, 8'h10);

        // R1 R2 R3 R5 sweep: every enable mask against every event pattern
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 8; p++) begin
                wd = {3'b111, 1'b1, p[0], m[2:0]};
                wr_ctrl(wd);
                rd_reg(1'b0, got); chk("R5 ctrl readback", got, wd & 8'h1F);
                pulse(p[2:0]);
                expv = {(|(p[2:0] & m[2:0])), 4'b0, p[2:0]};
                chk("R2 irq level", {7'b0, irq_drive_low}, {7'b0, expv[7]});
                rd_reg(1'b1, got); chk("R1 R2 status", got, expv);
                chk("R3 irq released", {7'b0, irq_drive_low}, 8'h00);
                rd_reg(1'b1, got); chk("R3 flags cleared", got, 8'h00);
            end
        end

        // R4: event coincides with clearing read
        wr_ctrl(8'h07);
        pulse(3'b010);
        @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b1; set_evt(3'b001);
        @(negedge clk); reg_rd = 1'b0; set_evt(3'b000);
        chk("R4 read shows old flags", rd_data, 8'h82);
        chk("R4 irq still held", {7'b0, irq_drive_low}, 8'h01);
        rd_reg(1'b1, got); chk("R4 new flag kept", got, 8'h81);

        // R6 R8: pin reset with good supply
        wr_ctrl(8'h0F);
        pulse(3'b111);
        @(negedge clk); ext_reset_n = 1'b0;
        @(negedge clk);
        chk("R6 irq", {7'b0, irq_drive_low}, 8'h00);
        chk("R6 sqw/ce", {6'b0, sqw_en, chip_en_out}, 8'h01);
        wr_ctrl(8'h0F);
        pulse(3'b111);
        chk("R8 write ignored in reset", {6'b0, sqw_en, chip_en_out}, 8'h01);
        @(negedge clk); ext_reset_n = 1'b1;
        rd_reg(1'b0, got); chk("R6 ctrl cleared", got, 8'h10);
        rd_reg(1'b1, got); chk("R6 flags cleared", got, 8'h00);

        // R7 R8: low supply
        wr_ctrl(8'h0F);
        pulse(3'b111);
        rd_reg(1'b0, got);
        @(negedge clk); supply_ok = 1'b0; ext_reset_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 irq held", {7'b0, irq_drive_low}, 8'h01);
        chk("R7 sqw/ce held", {6'b0, sqw_en, chip_en_out}, 8'h02);
        ext_reset_n = 1'b1;
        wr_ctrl(8'h10);
        chk("R8 write ignored low supply", {6'b0, sqw_en, chip_en_out}, 8'h02);
        rd_reg(1'b1, got);
        chk("R8 rd_data held", got, 8'h0F);
        chk("R8 irq not cleared", {7'b0, irq_drive_low}, 8'h01);
        @(negedge clk); supply_ok = 1'b1;
        rd_reg(1'b1, got); chk("R8 flags kept", got, 8'h87);

        // R9: system reset mid-run
        wr_ctrl(8'h0F);
        pulse(3'b100);
        rd_reg(1'b0, got);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R9 rd_data cleared", rd_data, 8'h00);
        chk("R9 irq cleared", {7'b0, irq_drive_low}, 8'h00);
        chk("R9 sqw/ce", {6'b0, sqw_en, chip_en_out}, 8'h01);
        rst_n = 1'b1;
        rd_reg(1'b1, got); chk("R9 flags cleared", got, 8'h00);
        finish_run();
    end
endmodule